// File: doc/BRIEF.md
# Banked Edge-Event Capture Controller

This block watches a set of digital input lines, organised as 8-bit ports, and latches a sticky event flag on a line when that line shows the edge chosen for its group of four. Each line has its own arm bit. Software arms a line by writing a 1 to its bit. Writing a 0 to the bit disarms the line and drops its flag. Flags are combined into per-port summaries and one global flag. That global flag drives an interrupt request output when an interrupt enable bit is set.

Software reaches the block through a byte-wide register window with eight offsets. A bank register at offset 7 chooses what the other offsets mean. Bank 0 shows the synchronised input levels and holds the interrupt enable. Bank 1 holds the event flags, the arm bits, the polarity control and the interrupt summary. Bank 2 is the debounce bank. Its registers are not part of this block and read as zero. Each input passes through a two-stage synchroniser before edge detection.

Top module: `edge_event_bank`

## Requirements
- R1: After reset the bank register holds 0. All event flags, arm bits, polarity bits and the interrupt enable are 0, and irqReq is 0.
- R2: A write to offset 7 in any bank loads the bank from data bits 7:6 (00 inputs, 01 events, 10 debounce). A read of offset 7 returns the bank in bits 7:6 and zeros in bits 5:0.
- R3: A write to offset 7 whose bits 7:6 are 11 leaves the bank unchanged.
- R4: In bank 0, offsets 0 to 3 read the synchronised levels of lines 8p+7 down to 8p for port p.
- R5: In bank 1, offsets 0 to 3 read the event flags of port p, with bit b belonging to line 8p+b.
- R6: Writing 0 to bit b of a port in bank 1 clears that line's flag and disarms the line. The line captures no edge until a 1 is written to the same bit.
- R7: Writing 1 to a bit arms the line and leaves its flag unchanged. A line that has never been armed never sets its flag.
- R8: A write to offset 6 in bank 1 sets the polarity. Bit g governs lines 4g to 4g+3. A 0 captures high-to-low edges and a 1 captures low-to-high edges.
- R9: A read of offset 6 in bank 1 returns the per-port summary. Bit p is the OR of the flags of port p. Bits 6:4 are 0, and bit 7 is the OR of bits 3:0.
- R10: Bit 0 of offset 6 in bank 0 is the interrupt enable, and it reads back at the same place. irqReq equals bank 1 offset 6 bit 7 ANDed with this enable.
- R11: An input change applied before clock edge k sets the flag of an armed line at edge k+2. The flag then stays set across further input activity until it is cleared.
- R12: Offsets 4 and 5 in every bank, and offsets 0 to 6 in bank 2, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineIn | input | 32 | Asynchronous input lines |
| regAddr | input | 3 | Register offset |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data, combinational from regAddr and state |
| irqReq | output | 1 | Interrupt request |

## Verification
Register writes take effect at the clock edge that samples regWrEn, and read data follows the address within the same cycle. The bench therefore drives the address at a falling edge and samples shortly afterwards. An input change takes two edges to reach the synchronised level and one more edge to reach a flag. The bench checks that a flag is still clear after two edges and set after the third. In the randomised phase it waits four edges after each input change before comparing the whole register window against its model.

// File: rtl/eeb_pkg.sv
package eeb_pkg;
  localparam int NUM_PORTS  = 4;
  localparam int PORT_W     = 8;
  localparam int GROUP_W    = 4;
  localparam int NUM_LINES  = NUM_PORTS * PORT_W;
  localparam int NUM_GROUPS = NUM_LINES / GROUP_W;
  localparam int ADDR_W     = 3;

  typedef enum logic [1:0] {
    BANK_INPUT  = 2'b00,
    BANK_EVENT  = 2'b01,
    BANK_FILTER = 2'b10,
    BANK_BAD    = 2'b11
  } bank_e;

  typedef struct packed {
    logic [NUM_PORTS-1:0] portWr;
    logic [PORT_W-1:0]    data;
  } ctrlStrobes_t;
endpackage

// File: rtl/eeb_datapath.sv
module eeb_datapath
  import eeb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_LINES-1:0]  lineIn,
  input  logic [NUM_GROUPS-1:0] groupPol,
  input  ctrlStrobes_t          strobe,
  output logic [NUM_LINES-1:0]  syncLines,
  output logic [NUM_LINES-1:0]  eventFlag
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0][NUM_LINES-1:0] syncQ;
  logic [NUM_LINES-1:0] prevQ;
  logic [NUM_LINES-1:0] armQ;
  logic [NUM_LINES-1:0] edgeHit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      syncQ <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= lineIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST];
    end
  end

  assign syncLines = syncQ[LAST];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_edge
    logic riseHit, fallHit;
    assign riseHit = syncQ[LAST][i] & ~prevQ[i];
    assign fallHit = ~syncQ[LAST][i] & prevQ[i];
    assign edgeHit[i] = groupPol[i / GROUP_W] ? riseHit : fallHit;
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    always_ff @(posedge clk) begin
      if (!rstN) begin
        armQ[p*PORT_W +: PORT_W]      <= '0;
        eventFlag[p*PORT_W +: PORT_W] <= '0;
      end else begin
        for (int b = 0; b < PORT_W; b++) begin
          if (strobe.portWr[p] && !strobe.data[b]) begin
            armQ[p*PORT_W + b]      <= 1'b0;
            eventFlag[p*PORT_W + b] <= 1'b0;
          end else begin
            if (strobe.portWr[p]) armQ[p*PORT_W + b] <= 1'b1;
            if (armQ[p*PORT_W + b] && edgeHit[p*PORT_W + b])
              eventFlag[p*PORT_W + b] <= 1'b1;
          end
        end
      end
    end

    // R6: a zero written to a bit leaves that flag clear on the next cycle
    assert_clear_on_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
      strobe.portWr[p] |=>
        ((eventFlag[p*PORT_W +: PORT_W] & ~$past(strobe.data)) == '0));

    // R11: without a write to the port no flag falls
    assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
      !strobe.portWr[p] |=>
        (($past(eventFlag[p*PORT_W +: PORT_W]) & ~eventFlag[p*PORT_W +: PORT_W]) == '0));
  end

  // R7: a line that was not armed cannot raise its flag
  assert_unarmed_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((eventFlag & ~$past(eventFlag) & ~$past(armQ)) == '0));
endmodule

// File: rtl/eeb_ctrl.sv
module eeb_ctrl
  import eeb_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic                  regWrEn,
  input  logic [PORT_W-1:0]     regWrData,
  input  logic [NUM_LINES-1:0]  syncLines,
  input  logic [NUM_LINES-1:0]  eventFlag,
  output logic [PORT_W-1:0]     regRdData,
  output logic                  irqReq,
  output logic [NUM_GROUPS-1:0] groupPol,
  output ctrlStrobes_t          strobe
);
  localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] OFS_BANK = ADDR_W'(7);

  bank_e bankQ;
  logic  irqEnQ;
  logic [NUM_GROUPS-1:0] polQ;
  logic [NUM_PORTS-1:0]  portAny;
  logic                  anyEvent;
  logic                  bankWr;

  assign bankWr = regWrEn && (regAddr == OFS_BANK);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ  <= BANK_INPUT;
      irqEnQ <= 1'b0;
      polQ   <= '0;
    end else if (regWrEn) begin
      if (bankWr) begin
        if (regWrData[7:6] != 2'b11) bankQ <= bank_e'(regWrData[7:6]);
      end else if (regAddr == OFS_STAT) begin
        if (bankQ == BANK_INPUT) irqEnQ <= regWrData[0];
        if (bankQ == BANK_EVENT) polQ   <= regWrData[NUM_GROUPS-1:0];
      end
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_sum
    assign portAny[p] = |eventFlag[p*PORT_W +: PORT_W];
    assign strobe.portWr[p] = regWrEn && (bankQ == BANK_EVENT)
                              && (regAddr == ADDR_W'(p));
  end
  assign strobe.data = regWrData;
  assign anyEvent = |portAny;
  assign irqReq   = anyEvent & irqEnQ;
  assign groupPol = polQ;

  always_comb begin
    regRdData = '0;
    if (regAddr == OFS_BANK) begin
      regRdData[7:6] = bankQ;
    end else if (regAddr == OFS_STAT) begin
      if (bankQ == BANK_INPUT) regRdData[0] = irqEnQ;
      if (bankQ == BANK_EVENT) begin
        regRdData[NUM_PORTS-1:0] = portAny;
        regRdData[7] = anyEvent;
      end
    end else if (int'(regAddr) < NUM_PORTS) begin
      if (bankQ == BANK_INPUT) regRdData = syncLines[int'(regAddr)*PORT_W +: PORT_W];
      if (bankQ == BANK_EVENT) regRdData = eventFlag[int'(regAddr)*PORT_W +: PORT_W];
    end
  end

  // R3: the reserved bank code is never held
  assert_bank_legal_R3: assert property (@(posedge clk) disable iff (!rstN)
    bankQ != BANK_BAD);

  // R2: the bank changes only through a write to offset 7
  assert_bank_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    !bankWr |=> $stable(bankQ));

  // R10: the request never stands while the enable is clear
  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rstN)
    !irqEnQ |-> !irqReq);
endmodule

// File: rtl/edge_event_bank.sv
module edge_event_bank
  import eeb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_LINES-1:0] lineIn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic                 regWrEn,
  input  logic [PORT_W-1:0]    regWrData,
  output logic [PORT_W-1:0]    regRdData,
  output logic                 irqReq
);
  ctrlStrobes_t          strobe;
  logic [NUM_GROUPS-1:0] groupPol;
  logic [NUM_LINES-1:0]  syncLines;
  logic [NUM_LINES-1:0]  eventFlag;

  eeb_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrEn(regWrEn),
    .regWrData(regWrData), .syncLines(syncLines), .eventFlag(eventFlag),
    .regRdData(regRdData), .irqReq(irqReq), .groupPol(groupPol),
    .strobe(strobe)
  );

  eeb_datapath #(.SYNC_STAGES(2)) i_datapath (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .groupPol(groupPol),
    .strobe(strobe), .syncLines(syncLines), .eventFlag(eventFlag)
  );
endmodule

// File: tb/test_edge_event_bank.sv
module test_edge_event_bank;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] lineIn = '0;
  logic [2:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        irqReq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] mFlag = '0, mArm = '0, mLine = '0;
  logic [7:0]  mPol = '0;
  logic [1:0]  mBank = '0;
  logic        mIrqEn = 1'b0;

  edge_event_bank i_edge_event_bank (
    .clk(clk), .rstN(rstN), .lineIn(lineIn), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData),
    .irqReq(irqReq)
  );

  always #2 clk = ~clk;

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] expStatus();
    logic [7:0] s = '0;
    for (int p = 0; p < 4; p++) s[p] = |mFlag[p*8 +: 8];
    s[7] = |s[3:0];
    return s;
  endfunction

  function automatic logic [7:0] expRead(logic [2:0] a);
    logic [7:0] r = '0;
    if (a == 3'd7) r = {mBank, 6'b0};
    else if (mBank == 2'd0 && a < 3'd4) r = mLine[a*8 +: 8];
    else if (mBank == 2'd0 && a == 3'd6) r = {7'b0, mIrqEn};
    else if (mBank == 2'd1 && a < 3'd4) r = mFlag[a*8 +: 8];
    else if (mBank == 2'd1 && a == 3'd6) r = expStatus();
    return r;
  endfunction

  function automatic string tagFor(logic [2:0] a);
    if (a == 3'd7) return "R2";
    if (a == 3'd4 || a == 3'd5 || mBank == 2'd2) return "R12";
    if (a == 3'd6) return (mBank == 2'd0) ? "R10" : "R9";
    return (mBank == 2'd0) ? "R4" : "R5";
  endfunction

  task automatic rd(logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
    if (a == 3'd7) begin
      if (d[7:6] != 2'b11) mBank = d[7:6];
    end else if (a == 3'd6) begin
      if (mBank == 2'd0) mIrqEn = d[0];
      if (mBank == 2'd1) mPol = d;
    end else if (a < 3'd4 && mBank == 2'd1) begin
      for (int b = 0; b < 8; b++) begin
        if (!d[b]) begin mFlag[a*8+b] = 1'b0; mArm[a*8+b] = 1'b0; end
        else mArm[a*8+b] = 1'b1;
      end
    end
  endtask

  task automatic setLines(logic [31:0] nv);
    for (int i = 0; i < 32; i++)
      if (mArm[i] && mLine[i] != nv[i] && nv[i] == mPol[i/4]) mFlag[i] = 1'b1;
    @(negedge clk);
    lineIn = nv;
    mLine = nv;
    repeat (4) @(posedge clk);
  endtask

  task automatic checkAll();
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      check(tagFor(3'(a)), d, expRead(3'(a)));
    end
    checks++;
    if (irqReq !== (expStatus() >> 7 & mIrqEn)) begin
      errors++;
      $display("FAIL R10 irqReq actual %0b expected %0b", irqReq, expStatus() >> 7 & mIrqEn);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    // R1: reset state
    rd(3'd7, d); check("R1", d, 8'h00);
    checks++;
    if (irqReq !== 1'b0) begin errors++; $display("FAIL R1 irqReq actual %0b expected 0", irqReq); end
    checkAll();

    // R3: reserved bank code ignored
    wr(3'd7, 8'h40); wr(3'd7, 8'hFF);
    rd(3'd7, d); check("R3", d, 8'h40);

    // R7: unarmed lines do not capture
    setLines(32'hFFFF_FFFF); setLines(32'h0);
    rd(3'd0, d); check("R7", d, 8'h00);

    // R8 and R11: arm port 0, rising on group 0, falling on group 1
    wr(3'd6, 8'h01); wr(3'd0, 8'hFF);
    @(negedge clk); lineIn = 32'h0000_0011; mLine = lineIn;
    mFlag[0] = 1'b1;
    repeat (2) @(posedge clk);
    rd(3'd0, d); check("R11", d, 8'h00);
    @(posedge clk);
    rd(3'd0, d); check("R8", d, 8'h01);
    setLines(32'h0);
    rd(3'd0, d); check("R8", d, 8'h11);
    setLines(32'h11); setLines(32'h0);
    rd(3'd0, d); check("R11", d, 8'h11);

    // R7: writing 1 leaves the flag set
    wr(3'd0, 8'hFF);
    rd(3'd0, d); check("R7", d, 8'h11);

    // R6: clear disarms until rewritten
    wr(3'd0, 8'hEE);
    rd(3'd0, d); check("R6", d, 8'h00);
    setLines(32'h01); setLines(32'h10); setLines(32'h0);
    rd(3'd0, d); check("R6", d, 8'h00);
    wr(3'd0, 8'hFF); setLines(32'h01);
    rd(3'd0, d); check("R6", d, 8'h01);

    // R9 and R10: summary and gated request
    rd(3'd6, d); check("R9", d, 8'h81);
    checks++;
    if (irqReq !== 1'b0) begin errors++; $display("FAIL R10 irqReq actual %0b expected 0", irqReq); end
    wr(3'd7, 8'h00); wr(3'd6, 8'h01); checkAll();
    wr(3'd7, 8'h80); checkAll();
    wr(3'd7, 8'h40); checkAll();

    // randomised phase
    for (int it = 0; it < 300; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 4) setLines(mLine ^ $urandom());
      else if (op < 7) wr(3'($urandom_range(0, 3)), 8'($urandom()));
      else if (op == 7) wr(3'd6, 8'($urandom()));
      else if (op == 8) begin
        wr(3'd7, {2'($urandom_range(0, 3)), 6'h0});
        checkAll();
        wr(3'd7, 8'h40);
      end else begin
        wr(3'd7, 8'h00); wr(3'd6, 8'($urandom())); wr(3'd7, 8'h40);
      end
      if (it % 5 == 0) checkAll();
    end
    checkAll();

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule